// File: doc/BRIEF.md
# Accumulator Load Addressing Unit

This unit carries out the accumulator-load instructions of a small 8-bit microcontroller core. Each instruction uses one of five ways of finding its operand: a literal byte in the instruction stream, a data-RAM address in the instruction stream, a working register, a RAM byte pointed to by a working register, or a code-memory byte found by adding the accumulator to a 16-bit data pointer. Opcodes and operand bytes come from a program-memory read port. Data RAM and code memory are read through synchronous ports, each with one cycle of latency. Code reads for the indexed form share the program-memory port.

The unit executes one instruction for each `step` pulse. It starts at the program counter, writes the accumulator, advances the program counter, and then raises `done` for one clock. At the same time it reports on `cycles` the instruction's machine-cycle cost. Working registers R0 to R7 sit in data RAM at `bank*8 + n`. The bank comes from bits 4 and 3 of an internal status word. The status word, both data-pointer bytes and the accumulator can be loaded through a small write port while the unit is idle.

The states are ST_IDLE, ST_FETCH, ST_DECODE, ST_OPND, ST_PTR, ST_RAMWB and ST_CODEWB. The transitions are:
- ST_IDLE to ST_FETCH on `step`.
- ST_FETCH to ST_DECODE.
- ST_DECODE to ST_OPND for the immediate and direct forms, to ST_RAMWB for the register form, to ST_PTR for the indirect form, to ST_CODEWB for the indexed form, and to ST_IDLE for an illegal opcode.
- ST_OPND to ST_IDLE for the immediate form, and to ST_RAMWB for the direct form.
- ST_PTR to ST_RAMWB.
- ST_RAMWB to ST_IDLE, and ST_CODEWB to ST_IDLE.

Top module: `acc_load_unit`

## Requirements
- R1: Opcode 74h loads the next program byte into the accumulator, advances the PC by 2 and reports 1 cycle.
- R2: Opcode E5h reads data RAM at the address given by the next program byte, loads that byte into the accumulator, advances the PC by 2 and reports 1 cycle.
- R3: Opcodes E8h to EFh load working register n (n = opcode bits 2:0) from data RAM into the accumulator, advance the PC by 1 and report 1 cycle.
- R4: The working-register RAM address is bank*8 + n. The bank is status-word bits 4:3, and all other status bits have no effect.
- R5: Opcodes E6h and E7h use R0 or R1 of the current bank (n = opcode bit 0) as a RAM pointer and load the byte it points to. They advance the PC by 1.
- R6: Opcode 93h loads the code byte at {DPH,DPL} + zero-extended A, taken modulo 2^16. It advances the PC by 1 and reports 2 cycles.
- R7: Any other opcode pulses `illegal` for one clock, advances the PC by 1, leaves A unchanged and gives no `done`.
- R8: `done` is high for exactly one clock per completed load, in the same cycle that the new A and PC first appear. `cycles` is valid with it. The PC changes only in a `done` or `illegal` cycle.
- R9: A synchronous reset clears A, the PC, DPL, DPH and the status word, so bank 0 is selected.
- R10: While idle, `wr_en` writes `wr_data` to a register chosen by `wr_sel`: 0 selects the status word, 1 selects DPL, 2 selects DPH and 3 selects A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | Execute one instruction from the PC (sampled in ST_IDLE) |
| wr_en | input | 1 | Register write strobe, honoured only in ST_IDLE |
| wr_sel | input | 2 | Write target: 0 status, 1 DPL, 2 DPH, 3 A |
| wr_data | input | 8 | Write data |
| pm_addr | output | 16 | Program/code memory read address |
| pm_data | input | 8 | Program/code byte, one cycle after pm_addr |
| ram_addr | output | 8 | Data RAM read address |
| ram_rd | output | 1 | Data RAM read strobe |
| ram_data | input | 8 | Data RAM byte, one cycle after ram_addr |
| acc | output | 8 | Accumulator |
| pc | output | 16 | Program counter |
| done | output | 1 | One-clock pulse when A has been loaded |
| cycles | output | 2 | Machine-cycle cost of the finished load |
| illegal | output | 1 | One-clock pulse on an unsupported opcode |

## Verification
If the latched opcode or the state register goes wrong, the fault appears at the ports within the same instruction. The wrong RAM or code address then carries a wrong byte into `acc`, and the PC steps by the wrong length. The `done` pulse may also be missing or duplicated. All of this is visible at the `done` or `illegal` cycle, three to five clocks after `step`. A status word or data pointer holding a wrong value stays hidden until the next register, indirect or indexed load. The bench therefore reloads these registers and runs such a load straight after each change, including a wrapped 16-bit index sum.

// File: rtl/acl_pkg.sv
package acl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_DECODE, ST_OPND, ST_PTR, ST_RAMWB, ST_CODEWB
    } st_e;

    typedef enum logic [2:0] {
        M_IMM, M_DIR, M_REG, M_IND, M_IDX, M_BAD
    } mode_e;

    localparam logic [7:0] OP_IMM = 8'h74;
    localparam logic [7:0] OP_DIR = 8'hE5;
    localparam logic [7:0] OP_IDX = 8'h93;
    localparam int BANK_LSB = 3;
    localparam int BANK_W   = 2;
    localparam int RSEL_W   = 3;
endpackage

// File: rtl/acl_decode.sv
module acl_decode
    import acl_pkg::*;
(
    input  logic [7:0]        op,
    output mode_e             mode,
    output logic [1:0]        len,
    output logic [1:0]        cyc,
    output logic [RSEL_W-1:0] rsel
);
    always_comb begin
        mode = M_BAD;
        len  = 2'd1;
        cyc  = 2'd1;
        rsel = op[RSEL_W-1:0];
        if (op == OP_IMM) begin
            mode = M_IMM;
            len  = 2'd2;
        end else if (op == OP_DIR) begin
            mode = M_DIR;
            len  = 2'd2;
        end else if (op[7:3] == 5'b11101) begin
            mode = M_REG;
        end else if (op[7:1] == 7'b1110011) begin
            mode = M_IND;
            rsel = {{(RSEL_W-1){1'b0}}, op[0]};
        end else if (op == OP_IDX) begin
            mode = M_IDX;
            cyc  = 2'd2;
        end
    end
endmodule

// File: rtl/acl_addr.sv
module acl_addr
    import acl_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 8,
    parameter int RAW = 8
) (
    input  logic [BANK_W-1:0] bank,
    input  logic [RSEL_W-1:0] rsel,
    input  logic [AW-1:0]     dptr,
    input  logic [DW-1:0]     acc,
    output logic [RAW-1:0]    reg_addr,
    output logic [AW-1:0]     idx_addr
);
    localparam int REG_W = BANK_W + RSEL_W;

    assign reg_addr = RAW'({bank, rsel});
    assign idx_addr = dptr + AW'(acc);

    if (RAW < REG_W) begin : g_bad_width
        initial $error("RAW too narrow for bank register address");
    end
endmodule

// File: rtl/acc_load_unit.sv
module acc_load_unit
    import acl_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 8,
    parameter int RAW = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           step,
    input  logic           wr_en,
    input  logic [1:0]     wr_sel,
    input  logic [DW-1:0]  wr_data,
    output logic [AW-1:0]  pm_addr,
    input  logic [DW-1:0]  pm_data,
    output logic [RAW-1:0] ram_addr,
    output logic           ram_rd,
    input  logic [DW-1:0]  ram_data,
    output logic [DW-1:0]  acc,
    output logic [AW-1:0]  pc,
    output logic           done,
    output logic [1:0]     cycles,
    output logic           illegal
);
    localparam int HALF = AW / 2;

    st_e               state, nxt;
    logic [DW-1:0]     op_q, acc_q, psw_q;
    logic [HALF-1:0]   dpl_q, dph_q;
    logic [AW-1:0]     pc_q;
    logic              done_q, ill_q;
    logic [1:0]        cyc_q;

    logic [DW-1:0]     op_now;
    mode_e             mode;
    logic [1:0]        len, dcyc;
    logic [RSEL_W-1:0] rsel;
    logic [RAW-1:0]    reg_addr;
    logic [AW-1:0]     idx_addr;
    logic              wb;
    logic [DW-1:0]     wb_data;

    assign op_now = (state == ST_DECODE) ? pm_data : op_q;

    acl_decode u_dec (
        .op   (op_now),
        .mode (mode),
        .len  (len),
        .cyc  (dcyc),
        .rsel (rsel)
    );

    acl_addr #(.AW(AW), .DW(DW), .RAW(RAW)) u_addr (
        .bank     (psw_q[BANK_LSB +: BANK_W]),
        .rsel     (rsel),
        .dptr     ({dph_q, dpl_q}),
        .acc      (acc_q),
        .reg_addr (reg_addr),
        .idx_addr (idx_addr)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // Next state and memory-port outputs
    always_comb begin
        nxt      = state;
        pm_addr  = pc_q;
        ram_addr = '0;
        ram_rd   = 1'b0;
        unique case (state)
            ST_IDLE:  if (step) nxt = ST_FETCH;
            ST_FETCH: nxt = ST_DECODE;
            ST_DECODE: begin
                unique case (mode)
                    M_IMM, M_DIR: begin
                        pm_addr = pc_q + AW'(1);
                        nxt     = ST_OPND;
                    end
                    M_REG: begin
                        ram_addr = reg_addr;
                        ram_rd   = 1'b1;
                        nxt      = ST_RAMWB;
                    end
                    M_IND: begin
                        ram_addr = reg_addr;
                        ram_rd   = 1'b1;
                        nxt      = ST_PTR;
                    end
                    M_IDX: begin
                        pm_addr = idx_addr;
                        nxt     = ST_CODEWB;
                    end
                    default: nxt = ST_IDLE;
                endcase
            end
            ST_OPND: begin
                if (mode == M_DIR) begin
                    ram_addr = RAW'(pm_data);
                    ram_rd   = 1'b1;
                    nxt      = ST_RAMWB;
                end else begin
                    nxt = ST_IDLE;
                end
            end
            ST_PTR: begin
                ram_addr = RAW'(ram_data);
                ram_rd   = 1'b1;
                nxt      = ST_RAMWB;
            end
            ST_RAMWB, ST_CODEWB: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    assign wb = (state == ST_OPND && mode == M_IMM) ||
                (state == ST_RAMWB) || (state == ST_CODEWB);
    assign wb_data = (state == ST_RAMWB) ? ram_data : pm_data;

    // Architectural registers
    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= '0;
            acc_q  <= '0;
            psw_q  <= '0;
            dpl_q  <= '0;
            dph_q  <= '0;
            pc_q   <= '0;
            done_q <= 1'b0;
            ill_q  <= 1'b0;
            cyc_q  <= '0;
        end else begin
            done_q <= 1'b0;
            ill_q  <= 1'b0;
            if (state == ST_IDLE && wr_en) begin
                unique case (wr_sel)
                    2'd0: psw_q <= wr_data;
                    2'd1: dpl_q <= HALF'(wr_data);
                    2'd2: dph_q <= HALF'(wr_data);
                    default: acc_q <= wr_data;
                endcase
            end
            if (state == ST_DECODE) begin
                op_q <= pm_data;
                if (mode == M_BAD) begin
                    pc_q  <= pc_q + AW'(1);
                    ill_q <= 1'b1;
                end
            end
            if (wb) begin
                acc_q  <= wb_data;
                pc_q   <= pc_q + AW'(len);
                cyc_q  <= dcyc;
                done_q <= 1'b1;
            end
        end
    end

    assign acc     = acc_q;
    assign pc      = pc_q;
    assign done    = done_q;
    assign illegal = ill_q;
    assign cycles  = cyc_q;
endmodule

// File: rtl/acl_chk.sv
module acl_chk #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          done,
    input logic          illegal,
    input logic [DW-1:0] acc,
    input logic [AW-1:0] pc,
    input logic [1:0]    cycles
);
    // R8: done lasts a single clock
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: cycle report is 1 or 2 whenever done
    a_r8_cycles_valid: assert property (@(posedge clk) disable iff (rst)
        done |-> (cycles == 2'd1 || cycles == 2'd2));

    // R8: PC moves only when an instruction finishes
    a_r8_pc_only_on_finish: assert property (@(posedge clk) disable iff (rst)
        (!done && !illegal) |-> $stable(pc));

    // R7: illegal never coincides with done
    a_r7_no_done: assert property (@(posedge clk) disable iff (rst)
        !(done && illegal));

    // R7: illegal keeps A
    a_r7_acc_kept: assert property (@(posedge clk) disable iff (rst)
        illegal |-> $stable(acc));

    // R7: illegal advances PC by one
    a_r7_pc_plus1: assert property (@(posedge clk) disable iff (rst)
        illegal |-> pc == $past(pc) + AW'(1));

    // R9: reset clears A and PC
    a_r9_reset_clear: assert property (@(posedge clk)
        rst |=> (acc == '0 && pc == '0));
endmodule

bind acc_load_unit acl_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .done    (done),
    .illegal (illegal),
    .acc     (acc),
    .pc      (pc),
    .cycles  (cycles)
);

// File: tb/acc_load_unit_tb.sv
module acc_load_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [7:0]  wr_data = '0;
    logic [15:0] pm_addr;
    logic [7:0]  pm_q = '0;
    logic [7:0]  ram_addr;
    logic        ram_rd;
    logic [7:0]  ram_q = '0;
    logic [7:0]  acc;
    logic [15:0] pc;
    logic        done;
    logic [1:0]  cycles;
    logic        illegal;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    acc_load_unit u_dut (
        .clk(clk), .rst(rst), .step(step), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .pm_addr(pm_addr), .pm_data(pm_q),
        .ram_addr(ram_addr), .ram_rd(ram_rd), .ram_data(ram_q),
        .acc(acc), .pc(pc), .done(done), .cycles(cycles), .illegal(illegal)
    );

    // memory models
    logic [7:0] pmem [0:63];
    logic [7:0] ram  [0:255];

    function automatic logic [7:0] code(input logic [15:0] a);
        if (a < 16'd64) return pmem[a[5:0]];
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    always @(posedge clk) begin
        pm_q  <= code(pm_addr);
        ram_q <= ram[ram_addr];
    end

    // scoreboard
    typedef struct {
        logic [7:0]  acc;
        logic [15:0] pc;
        logic [1:0]  cyc;
        bit          ill;
        string       tag;
    } exp_t;
    exp_t q[$];
    logic [15:0] m_pc = '0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    bit done_prev = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (done_prev) chk(!done, "R8", "done width", done, 0);
            if (done || illegal) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R8", "unexpected completion", done, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(illegal == e.ill, e.tag, "illegal flag", illegal, e.ill);
                    chk(acc == e.acc, e.tag, "acc", acc, e.acc);
                    chk(pc == e.pc, e.tag, "pc", pc, e.pc);
                    if (!e.ill) chk(cycles == e.cyc, e.tag, "cycles", cycles, e.cyc);
                end
            end
            done_prev = done;
        end
    end

    task automatic issue(input logic [7:0] exp_acc, input int len,
                         input logic [1:0] cyc, input bit ill, input string tag);
        exp_t e;
        m_pc = m_pc + 16'(len);
        e.acc = exp_acc; e.pc = m_pc; e.cyc = cyc; e.ill = ill; e.tag = tag;
        q.push_back(e);
        @(negedge clk) step = 1'b1;
        @(negedge clk) step = 1'b0;
        for (int i = 0; i < 20 && q.size() != 0; i++) @(negedge clk);
        if (q.size() != 0) begin
            chk(1'b0, tag, "no completion", 0, 1);
            q.delete();
        end
        @(negedge clk);
    endtask

    task automatic wreg(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) pmem[i] = 8'h00;
        for (int i = 0; i < 256; i++) ram[i] = 8'(i) ^ 8'hC3;
        ram[8'h00] = 8'h40;
        ram[8'h01] = 8'h41;
        ram[8'h19] = 8'h55;
        pmem[0]  = 8'h93;
        pmem[1]  = 8'hEC;
        pmem[2]  = 8'h74; pmem[3] = 8'h6A;
        pmem[4]  = 8'hE5; pmem[5] = 8'h20;
        pmem[6]  = 8'hE6;
        pmem[7]  = 8'hE7;
        pmem[8]  = 8'hA5;
        pmem[9]  = 8'hEC;
        pmem[10] = 8'h74; pmem[11] = 8'h02;
        pmem[12] = 8'h93;
        pmem[13] = 8'hE9;
        pmem[14] = 8'hE7;
        pmem[15] = 8'h74; pmem[16] = 8'h05;
        pmem[17] = 8'h93;
        pmem[18] = 8'hEF;
        pmem[19] = 8'h93;
        pmem[20] = 8'hEB;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk(acc == 8'h00, "R9", "acc after reset", acc, 0);
        chk(pc == 16'h0000, "R9", "pc after reset", pc, 0);
        chk(!done && !illegal, "R9", "flags after reset", {done, illegal}, 0);

        // R9 R6: DPTR=0, A=0 -> code[0]
        issue(code(16'h0000), 1, 2'd2, 1'b0, "R9/R6 cleared dptr");
        // R3 R4: bank 0 R4
        issue(ram[8'h04], 1, 2'd1, 1'b0, "R3 bank0 r4");
        // R1 immediate
        issue(8'h6A, 2, 2'd1, 1'b0, "R1 immediate");
        // R2 direct
        issue(ram[8'h20], 2, 2'd1, 1'b0, "R2 direct");
        // R5 indirect through R0 and R1
        issue(ram[ram[8'h00]], 1, 2'd1, 1'b0, "R5 via r0");
        issue(ram[ram[8'h01]], 1, 2'd1, 1'b0, "R5 via r1");
        // R7 illegal: A keeps ram[41h]
        issue(ram[ram[8'h01]], 1, 2'd0, 1'b1, "R7 illegal");
        // R10 status write, R4 bank 1
        wreg(2'd0, 8'h08);
        issue(ram[8'h0C], 1, 2'd1, 1'b0, "R4 bank1 r4");
        issue(8'h02, 2, 2'd1, 1'b0, "R1 immediate 02");
        wreg(2'd1, 8'hFE);
        wreg(2'd2, 8'h01);
        issue(code(16'h0200), 1, 2'd2, 1'b0, "R6 01FE+02");
        // bank 3
        wreg(2'd0, 8'h18);
        issue(ram[8'h19], 1, 2'd1, 1'b0, "R4 bank3 r1");
        issue(ram[ram[8'h19]], 1, 2'd1, 1'b0, "R5 bank3 ptr");
        // R6 wrap of the 16-bit sum
        wreg(2'd1, 8'hFF);
        wreg(2'd2, 8'hFF);
        issue(8'h05, 2, 2'd1, 1'b0, "R1 immediate 05");
        issue(code(16'h0004), 1, 2'd2, 1'b0, "R6 wrap FFFF+05");
        issue(ram[8'h1F], 1, 2'd1, 1'b0, "R3 bank3 r7");
        // R10 accumulator write feeds the index sum
        wreg(2'd3, 8'h7F);
        issue(code(16'h007E), 1, 2'd2, 1'b0, "R10 acc write index");
        // R4 other status bits ignored: E7h -> bank 0
        wreg(2'd0, 8'hE7);
        issue(ram[8'h03], 1, 2'd1, 1'b0, "R4 ignored status bits");

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule